// File: doc/BRIEF.md
# Radio Interrupt Flag Controller

This block gathers the interrupt events of a packet radio's digital core into sticky flags and drives one combined interrupt line. Each hardware event arrives as a single-cycle pulse and sets its flag. The flag stays set until software clears it through a small synchronous register port. Software picks, in a control register, whether writing a 0 or writing a 1 clears a flag. It also picks the active level of the interrupt line and which receive condition counts as a detect event: carrier, preamble or sync word.

Two further flags report a receive timeout and a receive FIFO overwrite. Software can read them but cannot write them. They clear themselves when the radio core signals particular command strobes or mode entries. A hardware set that arrives in the same cycle as any clear always takes effect, so no event is lost.

Software reaches the block through an address, a write enable, write data and registered read data. The interrupt line is also registered.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x09, the enable register (address 1) reads 0x00, the status register (address 2) reads 0x00, and `irq_o` is 0.
- R2: A one-cycle event pulse sets its status flag, and the flag stays set. Status bit positions: 7 resend failure, 6 cycle timer, 5 FIFO low, 4 RX error, 3 RX detect, 2 calibration done, 1 RX done, 0 TX done.
- R3: Control bits [3:2] choose the source of RX detect (status bit 3): 00 is carrier, 01 is preamble, 10 and 11 are sync word. Pulses from the sources not chosen are ignored.
- R4: A write to the status register clears each flag whose written bit equals control bit 1. So with 0, writing 0 clears; with 1, writing 1 clears. Flags written with the other value keep their value, and a write never sets a flag.
- R5: When a set pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is at its active level when any status bit and its matching enable bit (same position, address 1) are both 1. Control bit 0 picks the active level: 1 is high, 0 is low. `irq_o` changes one clock after the flag, enable or polarity change that causes it.
- R7: Control bit 7 (RX timeout) is set by `ev_rx_timeout_i`. Writes do not change it. It clears on `cmd_light_sleep_i`, `mode_rx_cont_i`, `ev_wake_timer_i` or `mode_ack_i`.
- R8: Control bit 6 (RX FIFO overwrite) is set by `ev_rx_overwrite_i`. Writes do not change it. It clears on `cmd_fifo_reset_i` or `cmd_rx_i`.
- R9: Control bits [5:4] always read 0. Writes to address 3 change no register.
- R10: `reg_rdata_o` is registered. After a clock edge it shows the register that `reg_addr_i` selected before that edge. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| ev_tx_done_i | input | 1 | TX complete pulse |
| ev_rx_done_i | input | 1 | RX complete pulse |
| ev_cal_done_i | input | 1 | Calibration complete pulse |
| ev_det_carrier_i | input | 1 | Carrier detected pulse |
| ev_det_preamble_i | input | 1 | Preamble detected pulse |
| ev_det_sync_i | input | 1 | Sync word detected pulse |
| ev_rx_err_i | input | 1 | RX error pulse |
| ev_fifo_low_i | input | 1 | FIFO low threshold pulse |
| ev_cyc_timer_i | input | 1 | Cycle timer pulse |
| ev_resend_fail_i | input | 1 | Auto-resend TX failure pulse |
| ev_rx_timeout_i | input | 1 | RX timeout pulse |
| ev_rx_overwrite_i | input | 1 | RX FIFO overwrite pulse |
| cmd_light_sleep_i | input | 1 | Light-sleep strobe |
| mode_rx_cont_i | input | 1 | Continuous RX mode entry |
| ev_wake_timer_i | input | 1 | Wake-on-timer event |
| mode_ack_i | input | 1 | Auto-resend/auto-ack mode entry |
| cmd_fifo_reset_i | input | 1 | RX FIFO reset strobe |
| cmd_rx_i | input | 1 | RX strobe |
| irq_o | output | 1 | Combined interrupt line, registered |

## Verification
The bench aims at collisions: an event pulse that lands in the same cycle as a software clear, or as a light-sleep strobe. A design that let the clear win there would drop an interrupt for good. Clear polarity is tested both ways, with mixed bit patterns in each write. A wrong polarity would wipe flags that are still pending, or leave flags that were acknowledged. The bench times the interrupt line to the exact cycle after a change and flips its polarity while a flag is pending. An unregistered line, or one with its level inverted, shows up there. Each detect source is tried under every select value, and every auto-clear input is tried alone, so a crossed mux arm or a missing clear term each gives a wrong read-back.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  localparam int REG_AW  = 2;
  localparam int REG_DW  = 8;
  localparam int NUM_EVT = 8;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_EN   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

  // control register bit positions
  localparam int CB_TIMEOUT = 7;
  localparam int CB_OVW     = 6;
  localparam int CB_DETSEL  = 2;
  localparam int CB_CLRPOL  = 1;
  localparam int CB_IRQPOL  = 0;

  // status bit position of the detect event
  localparam int SB_DETECT = 3;

  typedef enum logic [1:0] {
    DET_CARRIER  = 2'b00,
    DET_PREAMBLE = 2'b01,
    DET_SYNC     = 2'b10,
    DET_SYNC_ALT = 2'b11
  } det_sel_e;

  localparam logic [1:0] DETSEL_RST = 2'b10;
  localparam logic       CLRPOL_RST = 1'b0;
  localparam logic       IRQPOL_RST = 1'b1;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit #(
  parameter int NCLR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic [NCLR-1:0] clr_i,
  output logic            flag_o
);
  always_ff @(posedge clk) begin
    if (rst)         flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (|clr_i) flag_o <= 1'b0;
  end

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  a_r7_r8_autoclear: assert property (@(posedge clk) disable iff (rst)
    ((|clr_i) && !set_i) |=> !flag_o);
  a_r7_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !(|clr_i)) |=> $stable(flag_o));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         sw_wr_i,
  input  logic [N-1:0] sw_data_i,
  input  logic         clr_pol_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic sw_clr;
    assign sw_clr = sw_wr_i && (sw_data_i[g] == clr_pol_i);

    always_ff @(posedge clk) begin
      if (rst)           flags_o[g] <= 1'b0;
      else if (set_i[g]) flags_o[g] <= 1'b1;
      else if (sw_clr)   flags_o[g] <= 1'b0;
    end

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flags_o[g]);
    a_r4_no_sw_set: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && !flags_o[g]) |=> !flags_o[g]);
    a_r4_keep_other: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && sw_wr_i && sw_data_i[g] != clr_pol_i) |=> $stable(flags_o[g]));
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import radio_irq_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output det_sel_e          det_sel_o,
  output logic              clr_pol_o,
  output logic              irq_pol_o,
  output logic [N-1:0]      en_o
);
  logic wr_ctrl, wr_en;
  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_en   = wr_i && (addr_i == ADDR_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      det_sel_o <= det_sel_e'(DETSEL_RST);
      clr_pol_o <= CLRPOL_RST;
      irq_pol_o <= IRQPOL_RST;
      en_o      <= '0;
    end else begin
      if (wr_ctrl) begin
        det_sel_o <= det_sel_e'(wdata_i[CB_DETSEL +: 2]);
        clr_pol_o <= wdata_i[CB_CLRPOL];
        irq_pol_o <= wdata_i[CB_IRQPOL];
      end
      if (wr_en) en_o <= wdata_i;
    end
  end

  a_r9_en_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_o));
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> ($stable(clr_pol_o) && $stable(irq_pol_o) && $stable(det_sel_o)));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int   N        = 8,
  parameter logic IDLE_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  input  logic         pol_i,
  output logic         irq_o
);
  logic pending;
  assign pending = |(flags_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= IDLE_RST;
    else     irq_o <= pol_i ? pending : !pending;
  end

  a_r6_level: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq_o == ($past(pol_i) ? $past(pending) : !$past(pending))));
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import radio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              ev_tx_done_i,
  input  logic              ev_rx_done_i,
  input  logic              ev_cal_done_i,
  input  logic              ev_det_carrier_i,
  input  logic              ev_det_preamble_i,
  input  logic              ev_det_sync_i,
  input  logic              ev_rx_err_i,
  input  logic              ev_fifo_low_i,
  input  logic              ev_cyc_timer_i,
  input  logic              ev_resend_fail_i,
  input  logic              ev_rx_timeout_i,
  input  logic              ev_rx_overwrite_i,
  input  logic              cmd_light_sleep_i,
  input  logic              mode_rx_cont_i,
  input  logic              ev_wake_timer_i,
  input  logic              mode_ack_i,
  input  logic              cmd_fifo_reset_i,
  input  logic              cmd_rx_i,
  output logic              irq_o
);
  det_sel_e             det_sel;
  logic                 clr_pol, irq_pol;
  logic [NUM_EVT-1:0]   en, flags, set_vec;
  logic                 det_pulse, to_flag, ovw_flag, stat_wr;
  logic [REG_DW-1:0]    rd_next;

  irq_cfg_regs #(.N(NUM_EVT)) cfg_i (
    .clk(clk), .rst(rst), .wr_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[NUM_EVT-1:0]), .det_sel_o(det_sel),
    .clr_pol_o(clr_pol), .irq_pol_o(irq_pol), .en_o(en)
  );

  always_comb begin
    unique case (det_sel)
      DET_CARRIER:  det_pulse = ev_det_carrier_i;
      DET_PREAMBLE: det_pulse = ev_det_preamble_i;
      DET_SYNC,
      DET_SYNC_ALT: det_pulse = ev_det_sync_i;
      default:      det_pulse = 1'b0;
    endcase
  end

  assign set_vec = {ev_resend_fail_i, ev_cyc_timer_i, ev_fifo_low_i, ev_rx_err_i,
                    det_pulse, ev_cal_done_i, ev_rx_done_i, ev_tx_done_i};
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);

  irq_flag_bank #(.N(NUM_EVT)) flags_i (
    .clk(clk), .rst(rst), .set_i(set_vec), .sw_wr_i(stat_wr),
    .sw_data_i(reg_wdata_i[NUM_EVT-1:0]), .clr_pol_i(clr_pol), .flags_o(flags)
  );

  irq_sticky_bit #(.NCLR(4)) timeout_i (
    .clk(clk), .rst(rst), .set_i(ev_rx_timeout_i),
    .clr_i({cmd_light_sleep_i, mode_rx_cont_i, ev_wake_timer_i, mode_ack_i}),
    .flag_o(to_flag)
  );

  irq_sticky_bit #(.NCLR(2)) overwrite_i (
    .clk(clk), .rst(rst), .set_i(ev_rx_overwrite_i),
    .clr_i({cmd_fifo_reset_i, cmd_rx_i}), .flag_o(ovw_flag)
  );

  irq_out_stage #(.N(NUM_EVT), .IDLE_RST(!IRQPOL_RST)) out_i (
    .clk(clk), .rst(rst), .flags_i(flags), .en_i(en), .pol_i(irq_pol), .irq_o(irq_o)
  );

  always_comb begin
    rd_next = '0;
    case (reg_addr_i)
      ADDR_CTRL: begin
        rd_next[CB_TIMEOUT]       = to_flag;
        rd_next[CB_OVW]           = ovw_flag;
        rd_next[CB_DETSEL +: 2]   = det_sel;
        rd_next[CB_CLRPOL]        = clr_pol;
        rd_next[CB_IRQPOL]        = irq_pol;
      end
      ADDR_EN:   rd_next[NUM_EVT-1:0] = en;
      ADDR_STAT: rd_next[NUM_EVT-1:0] = flags;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_next;
  end

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr_i) == ADDR_CTRL) |-> (reg_rdata_o[5:4] == 2'b00));
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr_i) == 2'd3) |-> (reg_rdata_o == '0));
  a_r3_detect_masked: assert property (@(posedge clk) disable iff (rst)
    (det_sel == DET_CARRIER && !ev_det_carrier_i && !flags[SB_DETECT])
      |=> !flags[SB_DETECT]);
endmodule

// File: tb/radio_irq_ctrl_tb_top.sv
module radio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ev = '0;
  logic det_c = 0, det_p = 0, to_set = 0, ov_set = 0;
  logic [5:0] clr = '0;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  radio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .ev_tx_done_i(ev[0]), .ev_rx_done_i(ev[1]), .ev_cal_done_i(ev[2]),
    .ev_det_carrier_i(det_c), .ev_det_preamble_i(det_p), .ev_det_sync_i(ev[3]),
    .ev_rx_err_i(ev[4]), .ev_fifo_low_i(ev[5]), .ev_cyc_timer_i(ev[6]),
    .ev_resend_fail_i(ev[7]), .ev_rx_timeout_i(to_set), .ev_rx_overwrite_i(ov_set),
    .cmd_light_sleep_i(clr[0]), .mode_rx_cont_i(clr[1]), .ev_wake_timer_i(clr[2]),
    .mode_ack_i(clr[3]), .cmd_fifo_reset_i(clr[4]), .cmd_rx_i(clr[5]),
    .irq_o(irq)
  );

  // {enable, event mask, status write, write data, expected status, expected irq}
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {8'hFF, 8'h01, 1'b0, 8'h00, 8'h01, 1'b1},
    {8'hFF, 8'h02, 1'b1, 8'hFE, 8'h02, 1'b1},
    {8'h00, 8'h00, 1'b0, 8'h00, 8'h02, 1'b0},
    {8'h02, 8'h00, 1'b1, 8'hFF, 8'h02, 1'b1},
    {8'h02, 8'h04, 1'b1, 8'h00, 8'h04, 1'b0},
    {8'h04, 8'h04, 1'b1, 8'h00, 8'h04, 1'b1},
    {8'hFF, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0},
    {8'h80, 8'hC0, 1'b0, 8'h00, 8'hC0, 1'b1},
    {8'h80, 8'h38, 1'b1, 8'h7F, 8'h78, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [7:0] m, input logic c, input logic p,
                       input logic t, input logic o, input logic [5:0] cl);
    @(negedge clk); ev = m; det_c = c; det_p = p; to_set = t; ov_set = o; clr = cl;
    @(negedge clk); ev = '0; det_c = 0; det_p = 0; to_set = 0; ov_set = 0; clr = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 8'h09);
    rd(2'd1, r); check("R1 enable", r, 8'h00);
    rd(2'd2, r); check("R1 status", r, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd3, r); check("R10 unmapped", r, 8'h00);

    // vector table: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i][33:26]);
      @(negedge clk);
      ev = VEC[i][25:18];
      if (VEC[i][17]) begin addr = 2'd2; wdata = VEC[i][16:9]; we = 1'b1; end
      @(negedge clk);
      ev = '0; we = 1'b0;
      rd(2'd2, r);
      check($sformatf("R2/R4/R5 vec%0d status", i), r, VEC[i][8:1]);
      check($sformatf("R6 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R6 one-clock latency
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h01);
    @(negedge clk); ev = 8'h01;
    @(negedge clk); ev = '0;
    check("R6 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R6 irq after one clock", {7'd0, irq}, 8'h01);
    // R6 active-low polarity
    wr(2'd0, 8'h08);
    @(negedge clk);
    check("R6 active low asserted", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h00);
    @(negedge clk);
    check("R6 active low idle", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h09);

    // R4 write-1-to-clear
    wr(2'd0, 8'h0B);
    pulse(8'h03, 0, 0, 0, 0, '0);
    wr(2'd2, 8'h01);
    rd(2'd2, r); check("R4 w1c clears bit0 only", r, 8'h02);
    wr(2'd2, 8'h00);
    rd(2'd2, r); check("R4 w1c zeros no effect", r, 8'h02);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h09);

    // R3 detect source select
    wr(2'd0, 8'h01);
    pulse(8'h08, 0, 1, 0, 0, '0);
    rd(2'd2, r); check("R3 carrier ignores others", r, 8'h00);
    pulse(8'h00, 1, 0, 0, 0, '0);
    rd(2'd2, r); check("R3 carrier sets", r, 8'h08);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    pulse(8'h08, 1, 0, 0, 0, '0);
    rd(2'd2, r); check("R3 preamble ignores others", r, 8'h00);
    pulse(8'h00, 0, 1, 0, 0, '0);
    rd(2'd2, r); check("R3 preamble sets", r, 8'h08);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h0D);
    pulse(8'h00, 1, 1, 0, 0, '0);
    rd(2'd2, r); check("R3 sync alt ignores others", r, 8'h00);
    pulse(8'h08, 0, 0, 0, 0, '0);
    rd(2'd2, r); check("R3 sync alt sets", r, 8'h08);
    wr(2'd2, 8'h00);

    // R9 reserved bits and unmapped writes
    wr(2'd0, 8'hFF);
    rd(2'd0, r); check("R9 reserved read zero", r, 8'h0F);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h5A);
    wr(2'd3, 8'hFF);
    rd(2'd1, r); check("R9 addr3 write ignored", r, 8'h5A);
    rd(2'd3, r); check("R10 addr3 reads zero", r, 8'h00);

    // R7 timeout flag
    pulse(8'h00, 0, 0, 1, 0, '0);
    rd(2'd0, r); check("R7 timeout set", r, 8'h89);
    wr(2'd0, 8'h09);
    rd(2'd0, r); check("R7 timeout write ignored", r, 8'h89);
    for (int k = 0; k < 4; k++) begin
      pulse(8'h00, 0, 0, 1, 0, '0);
      pulse(8'h00, 0, 0, 0, 0, 6'(1 << k));
      rd(2'd0, r); check($sformatf("R7 timeout clear input %0d", k), r, 8'h09);
    end
    pulse(8'h00, 0, 0, 1, 0, 6'h01);
    rd(2'd0, r); check("R5 R7 set beats sleep", r, 8'h89);
    pulse(8'h00, 0, 0, 0, 0, 6'h30);
    rd(2'd0, r); check("R7 timeout ignores FIFO strobes", r, 8'h89);
    pulse(8'h00, 0, 0, 0, 0, 6'h01);

    // R8 overwrite flag
    pulse(8'h00, 0, 0, 0, 1, '0);
    rd(2'd0, r); check("R8 overwrite set", r, 8'h49);
    pulse(8'h00, 0, 0, 0, 0, 6'h0F);
    rd(2'd0, r); check("R8 ignores timeout clears", r, 8'h49);
    pulse(8'h00, 0, 0, 0, 0, 6'h10);
    rd(2'd0, r); check("R8 cleared by FIFO reset", r, 8'h09);
    pulse(8'h00, 0, 0, 0, 1, '0);
    pulse(8'h00, 0, 0, 0, 0, 6'h20);
    rd(2'd0, r); check("R8 cleared by RX strobe", r, 8'h09);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule